// File: doc/BRIEF.md
# Receive Signal Detect Monitor

The monitor sits behind a deserializer that delivers two 10-bit line characters per receive-clock cycle. It decides whether the incoming link carries valid coded data and presents that verdict on a single signal-detect output. The verdict is formed over fixed evaluation periods of four receive clocks and is then held for the whole of the following period.

Four criteria must all hold during a period for the output to be high after it. The amplitude-OK flag from the analog front end, passed through a synchronizer, must not drop. No valid character may be all zeros. No valid character may be all ones. A negative-disparity comma character must also have been seen recently: a character counter restarts on each such comma, and once it runs past a long window the comma criterion stays failed until another one arrives.

Top module: `sig_detect_mon`

## Requirements
- R1: While `rst_ni` is low, `sig_det_o` is 0. After reset is released it stays 0 until the first period in which every criterion holds has ended. The amplitude synchronizer resets to the failed state.
- R2: `sig_det_o` changes only on the clock edge that ends an evaluation period. These are the edges numbered 4, 8, 12, … after reset is released. The output holds its value between those edges.
- R3: On an ending edge, `sig_det_o` becomes 1 if no criterion failed in any of the four cycles of that period, and 0 otherwise.
- R4: A valid character equal to 10'b0000000000 on either lane fails the period in which it is sampled.
- R5: A valid character equal to 10'b1111111111 on either lane fails the period in which it is sampled.
- R6: `amp_ok_i` passes through a two-stage synchronizer. A low level sampled on edge k fails the cycles at edges k+2 and beyond, for as long as it lasts. A single-cycle drop therefore fails the period that contains edge k+2.
- R7: A valid character equal to 10'b0011111010 (bit 9 received first) on either lane restarts the comma window. Once 65,560 valid characters have passed without such a comma, every cycle fails until one is seen. The cycle on which the comma arrives still counts as failed.
- R8: Characters presented while `char_vld_i` is low are ignored. They are not checked, and they are not counted in the comma window.
- R9: No other value restarts the comma window, including the positive-disparity form 10'b1100000101.
- R10: Lane 0 is `char_i[9:0]` and is the earlier character. Lane 1 is `char_i[19:10]`. Both lanes are checked on every valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_i | input | 20 | Two received characters; lane 0 in bits 9:0 |
| char_vld_i | input | 1 | Both characters on `char_i` are valid this cycle |
| amp_ok_i | input | 1 | Asynchronous amplitude-OK flag from the analog front end |
| sig_det_o | output | 1 | Signal detect, updated once per four-clock period |

## Verification
The sharpest corner is the comma window boundary. The bench sends a comma and then exactly 8,195 comma-free periods, expecting the output still high. One more period must drive it low. A counter that was off by one period, or that accepted the positive-disparity comma, would miss one of these two checks. A bad character on a single beat in the middle of a period, and a one-cycle amplitude drop, test that failures are accumulated across the whole period. They also catch an output that changes before the period ends. The two-cycle synchronizer skew, which makes an amplitude drop also fail the following period, is checked explicitly. So are invalid cycles carrying all-zeros and all-ones characters, which a design that ignored the valid strobe would reject.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int CHAR_W = 10;
  // negative running disparity comma, bit 9 received first
  localparam logic [CHAR_W-1:0] COMMA_NEG = 10'b0011111010;
endpackage

// File: rtl/sdm_amp_sync.sv
module sdm_amp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/sdm_char_check.sv
module sdm_char_check
  import sdm_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [LANES*CHAR_W-1:0] chars_i,
  input  logic                    vld_i,
  output logic                    bad_o,
  output logic                    comma_o
);
  logic [LANES-1:0] zero_w, ones_w, comma_w;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CHAR_W-1:0] ch;
    assign ch         = chars_i[l*CHAR_W +: CHAR_W];
    assign zero_w[l]  = (ch == '0);
    assign ones_w[l]  = &ch;
    assign comma_w[l] = (ch == COMMA_NEG);
  end

  assign bad_o   = vld_i & ((|zero_w) | (|ones_w));
  assign comma_o = vld_i & (|comma_w);
endmodule

// File: rtl/sdm_comma_window.sv
module sdm_comma_window #(
  parameter int LANES  = 2,
  parameter int WINDOW = 65560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic comma_i,
  output logic expired_o
);
  localparam int CW = $clog2(WINDOW + LANES + 1);

  logic [CW-1:0] cnt_q;
  logic          exp_q;

  assign exp_q = (cnt_q >= CW'(WINDOW));

  // saturates: stops counting once expired
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (comma_i)          cnt_q <= '0;
    else if (vld_i && !exp_q)  cnt_q <= cnt_q + CW'(LANES);
  end

  assign expired_o = exp_q;
endmodule

// File: rtl/sdm_eval_period.sv
module sdm_eval_period #(
  parameter int EVAL_CLKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  output logic sig_o
);
  localparam int PW = $clog2(EVAL_CLKS);

  logic [PW-1:0] ph_q;
  logic          acc_q, sig_q, last_w;

  assign last_w = (ph_q == PW'(EVAL_CLKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      acc_q <= 1'b0;
      sig_q <= 1'b0;
    end else if (last_w) begin
      ph_q  <= '0;
      acc_q <= 1'b0;
      sig_q <= !(acc_q | fail_i);
    end else begin
      ph_q  <= ph_q + PW'(1);
      acc_q <= acc_q | fail_i;
    end
  end

  assign sig_o = sig_q;
endmodule

// File: rtl/sig_detect_mon.sv
module sig_detect_mon
  import sdm_pkg::*;
#(
  parameter int LANES        = 2,
  parameter int EVAL_CLKS    = 4,
  parameter int COMMA_WINDOW = 65560,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LANES*CHAR_W-1:0] char_i,
  input  logic                    char_vld_i,
  input  logic                    amp_ok_i,
  output logic                    sig_det_o
);
  logic amp_ok_s, bad_w, comma_w, expired_w, fail_w;

  sdm_amp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (amp_ok_i),
    .q_o   (amp_ok_s)
  );

  sdm_char_check #(.LANES(LANES)) u_chk_chars (
    .chars_i(char_i),
    .vld_i  (char_vld_i),
    .bad_o  (bad_w),
    .comma_o(comma_w)
  );

  sdm_comma_window #(.LANES(LANES), .WINDOW(COMMA_WINDOW)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (char_vld_i),
    .comma_i  (comma_w),
    .expired_o(expired_w)
  );

  assign fail_w = !amp_ok_s | bad_w | expired_w;

  sdm_eval_period #(.EVAL_CLKS(EVAL_CLKS)) u_eval (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fail_i(fail_w),
    .sig_o (sig_det_o)
  );
endmodule

// File: rtl/sdm_checker.sv
module sdm_checker
  import sdm_pkg::*;
#(
  parameter int LANES        = 2,
  parameter int EVAL_CLKS    = 4,
  parameter int COMMA_WINDOW = 65560
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [LANES*CHAR_W-1:0] char_i,
  input logic                    char_vld_i,
  input logic                    sig_det_o
);
  localparam int PW      = $clog2(EVAL_CLKS);
  localparam int GAP_MAX = COMMA_WINDOW + 4 * LANES * EVAL_CLKS;
  localparam int GW      = $clog2(GAP_MAX + LANES + 1);

  logic [PW-1:0] ph_q;
  logic          pend_q, bad_now, comma_now;
  logic [GW-1:0] gap_q;

  always_comb begin
    bad_now   = 1'b0;
    comma_now = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (char_i[l*CHAR_W +: CHAR_W] == '0 || &char_i[l*CHAR_W +: CHAR_W]) bad_now = char_vld_i;
      if (char_i[l*CHAR_W +: CHAR_W] == COMMA_NEG) comma_now = char_vld_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      pend_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      ph_q   <= (ph_q == PW'(EVAL_CLKS - 1)) ? '0 : ph_q + PW'(1);
      pend_q <= (ph_q == PW'(EVAL_CLKS - 1)) ? 1'b0 : (pend_q | bad_now);
      if (comma_now)                              gap_q <= '0;
      else if (char_vld_i && gap_q < GW'(GAP_MAX)) gap_q <= gap_q + GW'(LANES);
    end
  end

  // R1
  reset_low_chk: assert property (@(posedge clk_i) !rst_ni |-> !sig_det_o);

  // R2
  hold_in_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != '0) |-> $stable(sig_det_o));

  // R4 R5
  bad_char_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PW'(EVAL_CLKS - 1) && (pend_q || bad_now)) |=> !sig_det_o);

  // R7
  comma_gap_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_det_o |-> (gap_q <= GW'(COMMA_WINDOW + 2 * LANES * EVAL_CLKS)));
endmodule

bind sig_detect_mon sdm_checker #(
  .LANES       (LANES),
  .EVAL_CLKS   (EVAL_CLKS),
  .COMMA_WINDOW(COMMA_WINDOW)
) u_sdm_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .char_i    (char_i),
  .char_vld_i(char_vld_i),
  .sig_det_o (sig_det_o)
);

// File: tb/tb_sig_detect_mon.sv
module tb_sig_detect_mon;
  localparam logic [9:0] KN = 10'b0011111010;
  localparam logic [9:0] KP = 10'b1100000101;
  localparam logic [9:0] DD = 10'b0101010101;
  localparam logic [9:0] ZZ = 10'b0000000000;
  localparam logic [9:0] OO = 10'b1111111111;
  localparam int NV = 13;

  // {exp, vld, amp, lane1, lane0}
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, DD, KN},   // R6 sync warm-up
    {1'b1, 1'b1, 1'b1, DD, KN},   // R3
    {1'b0, 1'b1, 1'b1, DD, ZZ},   // R4 lane0
    {1'b1, 1'b1, 1'b1, KN, DD},   // R3
    {1'b0, 1'b1, 1'b1, OO, DD},   // R5 lane1 (R10)
    {1'b1, 1'b1, 1'b1, DD, KN},   // R3
    {1'b0, 1'b1, 1'b0, DD, DD},   // R6 amp low
    {1'b0, 1'b1, 1'b1, DD, DD},   // R6 sync skew
    {1'b1, 1'b1, 1'b1, DD, DD},   // R3
    {1'b1, 1'b0, 1'b1, OO, ZZ},   // R8 invalid ignored
    {1'b1, 1'b1, 1'b1, DD, KP},   // R9
    {1'b0, 1'b1, 1'b1, ZZ, OO},   // R4 R5
    {1'b1, 1'b1, 1'b1, DD, DD}    // R3
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] char_i = '0;
  logic        char_vld_i = 1'b0;
  logic        amp_ok_i = 1'b0;
  logic        sig_det_o;
  int          checks = 0;
  int          errors = 0;

  always #10 clk_i = ~clk_i;

  sig_detect_mon dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .char_i    (char_i),
    .char_vld_i(char_vld_i),
    .amp_ok_i  (amp_ok_i),
    .sig_det_o (sig_det_o)
  );

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (sig_det_o !== exp) begin
      errors++;
      $display("FAIL %s: sig_det_o=%b expected=%b", tag, sig_det_o, exp);
    end
  endtask

  task automatic beat(input logic [9:0] l0, input logic [9:0] l1,
                      input logic vld, input logic amp);
    char_i     = {l1, l0};
    char_vld_i = vld;
    amp_ok_i   = amp;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic period(input logic [9:0] l0, input logic [9:0] l1,
                        input logic vld, input logic amp);
    for (int b = 0; b < 4; b++) beat(l0, l1, vld, amp);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(1'b0, "R1 in reset");
    rst_ni = 1'b1;

    // table walk, one period per row
    for (int i = 0; i < NV; i++) begin
      period(VEC[i][9:0], VEC[i][19:10], VEC[i][21], VEC[i][20]);
      chk(VEC[i][22], $sformatf("R3 vector %0d", i));
    end

    // single-beat zero mid-period; output holds until period ends
    beat(DD, DD, 1'b1, 1'b1);
    beat(DD, ZZ, 1'b1, 1'b1);
    chk(1'b1, "R2 hold mid-period");
    beat(DD, DD, 1'b1, 1'b1);
    beat(DD, DD, 1'b1, 1'b1);
    chk(1'b0, "R4 single-beat zero lane1");
    period(DD, KN, 1'b1, 1'b1);
    chk(1'b1, "R3 recover");

    // one-cycle amplitude drop on first beat
    beat(DD, DD, 1'b1, 1'b0);
    beat(DD, DD, 1'b1, 1'b1);
    beat(DD, DD, 1'b1, 1'b1);
    beat(DD, DD, 1'b1, 1'b1);
    chk(1'b0, "R6 one-cycle amp drop");
    period(DD, DD, 1'b1, 1'b1);
    chk(1'b1, "R6 recover");

    // comma window boundary: last comma at end of this period
    period(KN, KN, 1'b1, 1'b1);
    chk(1'b1, "R7 comma period");
    for (int p = 0; p < 8195; p++) period(KP, DD, 1'b1, 1'b1);
    chk(1'b1, "R7 just inside window");
    period(KP, DD, 1'b1, 1'b1);
    chk(1'b0, "R7 R9 window expired");
    period(KP, DD, 1'b1, 1'b1);
    chk(1'b0, "R7 stays failed");
    beat(DD, KN, 1'b1, 1'b1);
    beat(DD, DD, 1'b1, 1'b1);
    beat(DD, DD, 1'b1, 1'b1);
    beat(DD, DD, 1'b1, 1'b1);
    chk(1'b0, "R7 comma period still fails");
    period(DD, DD, 1'b1, 1'b1);
    chk(1'b1, "R7 R10 lane1 comma restarts window");

    // reset while high
    #3 rst_ni = 1'b0;
    #1 chk(1'b0, "R1 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    period(KN, DD, 1'b1, 1'b1);
    chk(1'b0, "R1 first period after reset");
    period(KN, DD, 1'b1, 1'b1);
    chk(1'b1, "R1 second period after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule